// File: doc/BRIEF.md
# Tester Pin Channel with Local Vector Store

One channel of a digital IC tester, sitting next to one device pin. It keeps a local vector store of 128 test cycles, each split into two phases. Every phase carries a 3-bit code. The code either drives the pin (a steady level or a pulse) or turns the driver off and checks the sensed pin against an expectation. Strobes from a timing generator sequence the channel:

- `mux_tick` moves to the next phase.
- `mid_tick` marks the middle of a phase for pulse codes.
- `smp_tick` samples the sensed pin.

A one-bit serial port loads codes into the store and unloads captured response bits. A small set of control inputs chooses between two capture modes. In compare mode mismatches raise a sticky fail flag; in store mode each sample is kept for later unload. Other control inputs freeze the channel (a local hold and a global override) and detach its output or input timing (the output is then forced to tristate).

Top module: `vec_pin_channel`

## Requirements
- R1: After reset the phase pointer is 0 and every stored code is 3'b111, so `pin_oe`=0. After reset `fail`=0, `ser_out`=0 and `smp_last`=0.
- R2: Each `ser_wr` strobe takes one `ser_in` bit. Every three bits form one code, MSB first. Codes are written to successive phase addresses starting at 0. `restart` returns the write address to 0.
- R3: Code 3'b000 drives 0 and code 3'b001 drives 1, each with `pin_oe`=1.
- R4: Code 3'b010 drives 1 until `mid_tick` in that phase and then drives 0. Code 3'b011 does the opposite.
- R5: Any code with bit 2 set (3'b100 expect 0, 3'b101 expect 1, 3'b110 expect Z, 3'b111 don't care) gives `pin_oe`=0.
- R6: Each `mux_tick` advances the phase pointer by one and clears the mid-phase mark. After 256 phases the pointer wraps to phase 0.
- R7: In compare mode (`cfg_store`=0), `fail` is set at `smp_tick` in these cases:
  - expect 0 sees `pin_z`=1 or `pin_in`=1;
  - expect 1 sees `pin_z`=1 or `pin_in`=0;
  - expect Z sees `pin_z`=0.
  Once set, `fail` stays set until `restart`, which also returns the phase pointer to 0.
- R8: Don't care and drive codes never set `fail`.
- R9: In store mode (`cfg_store`=1), `smp_tick` writes `pin_in` into the response bit of the current phase and never sets `fail`. Each `ser_rd` strobe places the next response bit on `ser_out`, starting at phase 0. The bit appears in the cycle after the strobe.
- R10: While `cfg_local_hold` or `cfg_force_static` is 1, `mux_tick`, `mid_tick` and `smp_tick` have no effect.
- R11: `cfg_out_off`=1 forces `pin_oe`=0. `cfg_in_off`=1 makes `smp_tick` have no effect.
- R12: `smp_last` holds the `pin_in` value from the last `smp_tick` that took effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| restart | input | 1 | Rewind phase and serial pointers, clear fail |
| cfg_store | input | 1 | 1 = store samples, 0 = compare |
| cfg_local_hold | input | 1 | Local freeze of sequencing |
| cfg_force_static | input | 1 | Global freeze override |
| cfg_out_off | input | 1 | Detach output timing, tristate pin |
| cfg_in_off | input | 1 | Detach sample timing |
| mux_tick | input | 1 | Advance to next phase |
| mid_tick | input | 1 | Mid-phase mark for pulse codes |
| smp_tick | input | 1 | Sample strobe |
| pin_in | input | 1 | Sensed pin level |
| pin_z | input | 1 | Sensed pin is floating |
| pin_out | output | 1 | Drive level |
| pin_oe | output | 1 | Driver enable |
| fail | output | 1 | Sticky compare fail |
| smp_last | output | 1 | Last sampled level |
| ser_wr | input | 1 | Serial load strobe |
| ser_in | input | 1 | Serial load bit |
| ser_rd | input | 1 | Serial unload strobe |
| ser_out | output | 1 | Serial unload bit |

## Verification
The hardest state to reach from the ports is the phase-pointer wrap. To reach it, the channel runs from a loaded phase through 249 more phase advances. The bench then confirms that the drive code of phase 0 reappears. The other hard case is a fail that sticks through a matching compare. To reach it, the bench steps to an expect-0 phase and samples a 1, then steps to an expect-1 phase and samples a matching 1. Every freeze and detach setting is checked in a phase whose next phase drives a different level. That way a strobe that slipped through would show on `pin_out`.

// File: rtl/vpc_pkg.sv
package vpc_pkg;
    localparam int CODE_W = 3;

    localparam logic [CODE_W-1:0] C_DRV0 = 3'b000;
    localparam logic [CODE_W-1:0] C_DRV1 = 3'b001;
    localparam logic [CODE_W-1:0] C_PLS1 = 3'b010;
    localparam logic [CODE_W-1:0] C_PLS0 = 3'b011;
    localparam logic [CODE_W-1:0] C_EXP0 = 3'b100;
    localparam logic [CODE_W-1:0] C_EXP1 = 3'b101;
    localparam logic [CODE_W-1:0] C_EXPZ = 3'b110;
    localparam logic [CODE_W-1:0] C_XDC  = 3'b111;
endpackage

// File: rtl/vpc_store.sv
module vpc_store #(
    parameter int W = 3,
    parameter int DEPTH = 256,
    parameter logic [W-1:0] RST_VAL = '0,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= RST_VAL;
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/vpc_drive.sv
module vpc_drive
    import vpc_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    input  logic              half,
    input  logic              out_off,
    output logic              pin_out,
    output logic              pin_oe
);
    always_comb begin
        pin_out = 1'b0;
        pin_oe  = 1'b0;
        if (!out_off && !code[CODE_W-1]) begin
            pin_oe = 1'b1;
            unique case (code)
                C_DRV0:  pin_out = 1'b0;
                C_DRV1:  pin_out = 1'b1;
                C_PLS1:  pin_out = !half;
                C_PLS0:  pin_out = half;
                default: pin_out = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/vpc_sense.sv
module vpc_sense
    import vpc_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    input  logic              pin_in,
    input  logic              pin_z,
    output logic              mismatch
);
    always_comb begin
        unique case (code)
            C_EXP0:  mismatch = pin_z || pin_in;
            C_EXP1:  mismatch = pin_z || !pin_in;
            C_EXPZ:  mismatch = !pin_z;
            default: mismatch = 1'b0;
        endcase
    end
endmodule

// File: rtl/vec_pin_channel.sv
module vec_pin_channel
    import vpc_pkg::*;
#(
    parameter int CYCLES = 128,
    parameter int PHASES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic cfg_store,
    input  logic cfg_local_hold,
    input  logic cfg_force_static,
    input  logic cfg_out_off,
    input  logic cfg_in_off,
    input  logic mux_tick,
    input  logic mid_tick,
    input  logic smp_tick,
    input  logic pin_in,
    input  logic pin_z,
    output logic pin_out,
    output logic pin_oe,
    output logic fail,
    output logic smp_last,
    input  logic ser_wr,
    input  logic ser_in,
    input  logic ser_rd,
    output logic ser_out
);
    localparam int DEPTH = CYCLES * PHASES;
    localparam int AW    = $clog2(DEPTH);
    localparam int BUF_W = CODE_W - 1;

    typedef struct packed {
        logic [AW-1:0]    ph;
        logic             half;
        logic             fail;
        logic             smp;
        logic [1:0]       wcnt;
        logic [BUF_W-1:0] wbuf;
        logic [AW-1:0]    wptr;
        logic [AW-1:0]    rptr;
        logic             sout;
    } seq_t;

    seq_t s_d, s_q;

    logic [CODE_W-1:0] cur_code;
    logic [AW-1:0]     phase_idx;
    logic              run_en;
    logic              smp_take;
    logic              mismatch;
    logic              pat_we;
    logic [CODE_W-1:0] pat_wdata;
    logic              resp_we;
    logic              resp_rdata;

    assign phase_idx = s_q.ph;
    assign run_en    = !cfg_local_hold && !cfg_force_static;
    assign smp_take  = run_en && smp_tick && !cfg_in_off && !restart;
    assign pat_we    = ser_wr && !restart && (s_q.wcnt == 2'd2);
    assign pat_wdata = {s_q.wbuf, ser_in};
    assign resp_we   = smp_take && cfg_store;

    vpc_store #(.W(CODE_W), .DEPTH(DEPTH), .RST_VAL(C_XDC)) u_pat (
        .clk(clk), .rst_n(rst_n), .we(pat_we), .waddr(s_q.wptr),
        .wdata(pat_wdata), .raddr(s_q.ph), .rdata(cur_code)
    );

    vpc_store #(.W(1), .DEPTH(DEPTH), .RST_VAL(1'b0)) u_resp (
        .clk(clk), .rst_n(rst_n), .we(resp_we), .waddr(s_q.ph),
        .wdata(pin_in), .raddr(s_q.rptr), .rdata(resp_rdata)
    );

    vpc_drive u_drv (
        .code(cur_code), .half(s_q.half), .out_off(cfg_out_off),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    vpc_sense u_sns (
        .code(cur_code), .pin_in(pin_in), .pin_z(pin_z), .mismatch(mismatch)
    );

    always_comb begin
        s_d = s_q;
        if (restart) begin
            s_d.ph   = '0;
            s_d.half = 1'b0;
            s_d.fail = 1'b0;
            s_d.wcnt = '0;
            s_d.wbuf = '0;
            s_d.wptr = '0;
            s_d.rptr = '0;
        end else begin
            if (run_en && mux_tick) begin
                s_d.ph   = s_q.ph + 1'b1;
                s_d.half = 1'b0;
            end else if (run_en && mid_tick) begin
                s_d.half = 1'b1;
            end
            if (smp_take) begin
                s_d.smp = pin_in;
                if (!cfg_store && mismatch) s_d.fail = 1'b1;
            end
            if (ser_wr) begin
                if (s_q.wcnt == 2'd2) begin
                    s_d.wcnt = '0;
                    s_d.wptr = s_q.wptr + 1'b1;
                end else begin
                    s_d.wcnt = s_q.wcnt + 1'b1;
                    s_d.wbuf = {s_q.wbuf[BUF_W-2:0], ser_in};
                end
            end
            if (ser_rd) begin
                s_d.sout = resp_rdata;
                s_d.rptr = s_q.rptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign fail     = s_q.fail;
    assign smp_last = s_q.smp;
    assign ser_out  = s_q.sout;
endmodule

// File: rtl/vec_pin_channel_chk.sv
module vec_pin_channel_chk #(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          restart,
    input logic          run_en,
    input logic          mux_tick,
    input logic          cfg_store,
    input logic          cfg_out_off,
    input logic [2:0]    cur_code,
    input logic [AW-1:0] phase_idx,
    input logic          pin_oe,
    input logic          fail
);
    // R5
    sense_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cur_code[2] |-> !pin_oe);

    // R11
    out_detach_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_out_off |-> !pin_oe);

    // R7
    fail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && !restart) |=> fail);

    // R9
    store_nofail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_store && !fail && !restart) |=> !fail);

    // R10
    frozen_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !restart) |=> $stable(phase_idx));

    // R6
    phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && mux_tick && !restart) |=> (phase_idx == $past(phase_idx) + 1'b1));
endmodule

bind vec_pin_channel vec_pin_channel_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .restart(restart), .run_en(run_en),
    .mux_tick(mux_tick), .cfg_store(cfg_store), .cfg_out_off(cfg_out_off),
    .cur_code(cur_code), .phase_idx(phase_idx), .pin_oe(pin_oe), .fail(fail)
);

// File: tb/sim_vec_pin_channel.sv
`timescale 1ns/1ps
module sim_vec_pin_channel;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic restart = 0, cfg_store = 0, cfg_local_hold = 0, cfg_force_static = 0;
    logic cfg_out_off = 0, cfg_in_off = 0;
    logic mux_tick = 0, mid_tick = 0, smp_tick = 0, pin_in = 0, pin_z = 0;
    logic ser_wr = 0, ser_in = 0, ser_rd = 0;
    logic pin_out, pin_oe, fail, smp_last, ser_out;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    string q_req[$];
    int    q_kind[$];
    logic  q_exp[$];

    always #5 clk = ~clk;

    vec_pin_channel u0 (
        .clk(clk), .rst_n(rst_n), .restart(restart), .cfg_store(cfg_store),
        .cfg_local_hold(cfg_local_hold), .cfg_force_static(cfg_force_static),
        .cfg_out_off(cfg_out_off), .cfg_in_off(cfg_in_off),
        .mux_tick(mux_tick), .mid_tick(mid_tick), .smp_tick(smp_tick),
        .pin_in(pin_in), .pin_z(pin_z), .pin_out(pin_out), .pin_oe(pin_oe),
        .fail(fail), .smp_last(smp_last), .ser_wr(ser_wr), .ser_in(ser_in),
        .ser_rd(ser_rd), .ser_out(ser_out)
    );

    // kinds: 0 pin_out, 1 pin_oe, 2 fail, 3 ser_out, 4 smp_last
    task automatic want(input string r, input int k, input logic e);
        q_req.push_back(r);
        q_kind.push_back(k);
        q_exp.push_back(e);
    endtask

    function automatic logic observe(input int k);
        case (k)
            0: return pin_out;
            1: return pin_oe;
            2: return fail;
            3: return ser_out;
            default: return smp_last;
        endcase
    endfunction

    initial begin
        forever begin
            @(posedge clk);
            #3;
            while (q_req.size() > 0) begin
                string r;
                int k;
                logic e, a;
                r = q_req.pop_front();
                k = q_kind.pop_front();
                e = q_exp.pop_front();
                a = observe(k);
                compared++;
                if (a !== e) begin
                    mismatched++;
                    $display("FAIL %s kind=%0d actual=%b expected=%b", r, k, a, e);
                end
            end
        end
    end

    task automatic do_mux(input int n);
        @(negedge clk) mux_tick = 1;
        repeat (n) @(negedge clk);
        mux_tick = 0;
    endtask

    task automatic do_mid();
        @(negedge clk) mid_tick = 1;
        @(negedge clk) mid_tick = 0;
    endtask

    task automatic do_smp(input logic v, input logic z);
        @(negedge clk) begin smp_tick = 1; pin_in = v; pin_z = z; end
        @(negedge clk) smp_tick = 0;
    endtask

    task automatic do_restart();
        @(negedge clk) restart = 1;
        @(negedge clk) restart = 0;
    endtask

    task automatic ser_word(input logic [2:0] c);
        for (int b = 2; b >= 0; b--) begin
            @(negedge clk) begin ser_wr = 1; ser_in = c[b]; end
        end
        @(negedge clk) ser_wr = 0;
    endtask

    task automatic do_rd();
        @(negedge clk) ser_rd = 1;
        @(negedge clk) ser_rd = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog all-requirements actual=timeout expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        want("R1 oe", 1, 0); want("R1 fail", 2, 0); want("R1 ser_out", 3, 0); want("R1 smp", 4, 0);
        @(negedge clk);

        do_restart();
        ser_word(3'b000); ser_word(3'b001); ser_word(3'b010); ser_word(3'b011);
        ser_word(3'b100); ser_word(3'b101); ser_word(3'b110); ser_word(3'b111);
        want("R2/R3 drive0 out", 0, 0); want("R3 drive0 oe", 1, 1);

        do_smp(0, 0); want("R8 drive code no fail", 2, 0);
        do_smp(1, 0); want("R8 drive code no fail", 2, 0); want("R12 last sample", 4, 1);

        cfg_local_hold = 1;
        do_smp(0, 0); want("R10 hold smp ignored", 4, 1);
        do_mux(1); want("R10 hold mux ignored", 0, 0);
        cfg_local_hold = 0; cfg_force_static = 1;
        do_mux(1); want("R10 static mux ignored", 0, 0); want("R10 static oe", 1, 1);
        cfg_force_static = 0;

        @(negedge clk) cfg_out_off = 1;
        @(negedge clk); want("R11 out detached", 1, 0);
        @(negedge clk) cfg_out_off = 0;

        do_mux(1); want("R3/R6 drive1 out", 0, 1); want("R3 drive1 oe", 1, 1);
        do_mux(1); want("R4 pulse1 first half", 0, 1);
        do_mid();  want("R4 pulse1 second half", 0, 0);
        do_mux(1); want("R4/R6 pulse0 first half", 0, 0);
        do_mid();  want("R4 pulse0 second half", 0, 1);
        do_mux(1); want("R5 expect0 oe", 1, 0);
        do_smp(0, 0); want("R7 expect0 match", 2, 0);
        do_mux(1); want("R5 expect1 oe", 1, 0);
        do_smp(1, 0); want("R7 expect1 match", 2, 0);
        do_mux(1); want("R5 expectZ oe", 1, 0);
        do_smp(0, 1); want("R7 expectZ match", 2, 0);
        do_mux(1); want("R5 dontcare oe", 1, 0);
        do_smp(1, 1); want("R8 dontcare no fail", 2, 0);

        do_mux(249); want("R6 wrap out", 0, 0); want("R6 wrap oe", 1, 1);
        do_mux(4); do_smp(1, 0); want("R7 expect0 mismatch", 2, 1);
        do_mux(1); do_smp(1, 0); want("R7 fail sticky", 2, 1);
        do_restart(); want("R7 restart clears", 2, 0); want("R7 restart phase0", 1, 1);

        do_mux(4);
        cfg_in_off = 1;
        do_smp(1, 0); want("R11 in detached", 2, 0);
        cfg_in_off = 0;
        do_smp(1, 0); want("R7 expect0 mismatch", 2, 1);
        do_restart();
        do_mux(6); do_smp(0, 0); want("R7 expectZ mismatch", 2, 1);
        do_restart();
        do_mux(4); do_smp(0, 1); want("R7 expect0 floating", 2, 1);
        do_restart();

        cfg_store = 1;
        do_restart();
        do_smp(1, 0); do_mux(1);
        do_smp(0, 0); do_mux(1);
        do_smp(1, 0); do_mux(1);
        do_mux(1);
        do_smp(1, 0); want("R9 store no fail", 2, 0);
        do_rd(); want("R9 unload p0", 3, 1);
        do_rd(); want("R9 unload p1", 3, 0);
        do_rd(); want("R9 unload p2", 3, 1);
        do_rd(); want("R9 unload p3", 3, 0);
        do_rd(); want("R9 unload p4", 3, 1);
        cfg_store = 0;

        do_restart();
        ser_word(3'b001); want("R2 reload addr0", 0, 1); want("R2 reload oe", 1, 1);

        repeat (4) @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule